// File: doc/BRIEF.md
# Branch-Metric Ping-Pong Input Buffer

This block sits between a DMA-style master and a decoder core. It stores incoming 64-bit branch-metric words in two halves of equal size. While the core drains one half, the master refills the other. Each time a half runs empty, the block raises a single-cycle refill request. The master answers each request with a burst of writes. The length of that burst is fixed by a code-rate selector and a burst code, and it is 8 or 16 words.

A block-length input gives the total number of words the current code block needs. The block subtracts each request from that total, so the last request may be shorter than a full burst. No request is issued once the total has been requested, even when a half drains at the very end of the block. A start pulse loads the settings and the length, empties both halves and immediately primes them with two requests.

A write that arrives when the half due to be filled is not waiting for data is discarded. Such a write also sets a sticky error flag, which stays set until the next start.

Top module: `metric_pingpong`

## Requirements
- R1: While and right after reset, refillReq, rdValid and overflowErr are all low.
- R2: After start is sampled high at a clock edge, the first refillReq pulse is visible in the second cycle after that edge's cycle. When blockWords exceeds one burst, a second pulse follows in the very next cycle.
- R3: The burst length is 16 words when burstCode equals the long code for the rate, and 8 words otherwise. rateSel 2'b00 (rate 1/4) has long code 3. rateSel 2'b01 (rate 1/3) has long code 7. rateSel 2'b10 and 2'b11 (rate 1/2) have long code 15. The usual short codes are 1, 3 and 7.
- R4: Each request expects the smaller of the burst length and the words not yet requested. A half becomes readable once that many writes have been accepted into it. rdValid is high while a word is available, rdData shows the words in write order, and rdEn with rdValid consumes one word.
- R5: When the last word of a half is read and block words remain unrequested, a new request is issued for that half. No request is issued while both halves hold data or are awaiting data.
- R6: A block issues exactly ceil(blockWords / burst) requests, with none after the final half drains. A block of zero words issues none.
- R7: A write while the half due to be filled is not awaiting data is dropped. Such a write sets overflowErr, which then stays high until the next start.
- R8: Start abandons the current block. In the cycle after start, overflowErr, rdValid and refillReq are low.
- R9: rdEn while rdValid is low has no effect: the first word read afterwards is the first word written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a new block, loading rateSel, burstCode and blockWords |
| rateSel | input | 2 | Code-rate selector (00: 1/4, 01: 1/3, 1x: 1/2) |
| burstCode | input | 4 | Burst code, decoded against the rate |
| blockWords | input | LEN_W (16) | Total 64-bit words in the block |
| wrValid | input | 1 | Write strobe from the master |
| wrData | input | DATA_W (64) | Write word |
| refillReq | output | 1 | One-cycle request for one burst of writes |
| rdEn | input | 1 | Core consumes the word on rdData |
| rdValid | output | 1 | A word is available to the core |
| rdData | output | DATA_W (64) | Oldest unread word |
| overflowErr | output | 1 | Sticky flag for a dropped write |

## Verification
The hardest case to reach is the steady state in which both halves are filled and the core has stopped reading. In that state no request may appear, and requests must resume one at a time as each half drains. The stimulus reaches it by holding the reader idle for many cycles after start while the writer answers both priming requests, then checking the request count before reads resume. The end-of-block rule is exercised with lengths that divide the burst exactly, leave a short tail, fit in a single request and are zero. The read-while-empty rule is exercised by holding rdEn high before any write arrives.

// File: rtl/metric_pingpong_pkg.sv
package metric_pingpong_pkg;

  // Per-half occupancy state.
  typedef enum logic [1:0] {
    H_EMPTY = 2'd0,
    H_WAIT  = 2'd1,
    H_FULL  = 2'd2
  } halfState_e;

  // Strobes from control to the storage datapath.
  typedef struct packed {
    logic memWe;   // write the word on wrData at wrAddr
    logic rdLive;  // read half currently holds unread data
  } ppStrobe_t;

  // Long burst is chosen when the code matches the rate's long code.
  function automatic logic isLongBurst(input logic [1:0] rateSel,
                                       input logic [3:0] code);
    case (rateSel)
      2'b00:   return code == 4'd3;
      2'b01:   return code == 4'd7;
      default: return code == 4'd15;
    endcase
  endfunction

endpackage

// File: rtl/metric_pingpong_ctrl.sv
module metric_pingpong_ctrl
  import metric_pingpong_pkg::*;
#(
  parameter int HALF_WORDS = 16,
  parameter int LEN_W      = 16,
  localparam int PTR_W     = $clog2(HALF_WORDS),
  localparam int CNT_W     = $clog2(HALF_WORDS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [1:0]       rateSel,
  input  logic [3:0]       burstCode,
  input  logic [LEN_W-1:0] blockWords,
  input  logic             wrValid,
  input  logic             rdEn,
  output logic             refillReq,
  output logic             rdValid,
  output logic             overflowErr,
  output logic [PTR_W:0]   wrAddr,
  output logic [PTR_W:0]   rdAddr,
  output ppStrobe_t        strobe
);

  localparam int SHORT_WORDS = HALF_WORDS / 2;

  halfState_e       halfState [2];
  logic [CNT_W-1:0] halfLen   [2];
  logic             wrHalf, rdHalf, reqHalf;
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [LEN_W-1:0] remaining;
  logic [CNT_W-1:0] burstW;

  logic             issueNow, wrAccept, wrLast, rdFire, rdLast;
  logic [CNT_W-1:0] reqLen;
  logic [LEN_W-1:0] burstWide;

  assign burstWide = LEN_W'(burstW);
  assign reqLen    = (remaining < burstWide) ? CNT_W'(remaining) : burstW;
  assign issueNow  = !start && (halfState[reqHalf] == H_EMPTY) && (remaining != '0);

  assign wrAccept  = wrValid && !start && (halfState[wrHalf] == H_WAIT);
  assign wrLast    = CNT_W'(wrPtr) == (halfLen[wrHalf] - CNT_W'(1));

  assign rdValid   = halfState[rdHalf] == H_FULL;
  assign rdFire    = rdEn && rdValid && !start;
  assign rdLast    = CNT_W'(rdPtr) == (halfLen[rdHalf] - CNT_W'(1));

  assign wrAddr        = {wrHalf, wrPtr};
  assign rdAddr        = {rdHalf, rdPtr};
  assign strobe.memWe  = wrAccept;
  assign strobe.rdLive = rdValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int h = 0; h < 2; h++) begin
        halfState[h] <= H_EMPTY;
        halfLen[h]   <= '0;
      end
      wrHalf      <= 1'b0;
      rdHalf      <= 1'b0;
      reqHalf     <= 1'b0;
      wrPtr       <= '0;
      rdPtr       <= '0;
      remaining   <= '0;
      burstW      <= CNT_W'(SHORT_WORDS);
      refillReq   <= 1'b0;
      overflowErr <= 1'b0;
    end else if (start) begin
      for (int h = 0; h < 2; h++) begin
        halfState[h] <= H_EMPTY;
        halfLen[h]   <= '0;
      end
      wrHalf      <= 1'b0;
      rdHalf      <= 1'b0;
      reqHalf     <= 1'b0;
      wrPtr       <= '0;
      rdPtr       <= '0;
      remaining   <= blockWords;
      burstW      <= isLongBurst(rateSel, burstCode) ? CNT_W'(HALF_WORDS)
                                                     : CNT_W'(SHORT_WORDS);
      refillReq   <= 1'b0;
      overflowErr <= 1'b0;
    end else begin
      refillReq <= issueNow;
      // Request a burst for the next half in fill order.
      if (issueNow) begin
        halfState[reqHalf] <= H_WAIT;
        halfLen[reqHalf]   <= reqLen;
        remaining          <= remaining - LEN_W'(reqLen);
        reqHalf            <= ~reqHalf;
      end
      // Master writes.
      if (wrValid) begin
        if (wrAccept) begin
          if (wrLast) begin
            halfState[wrHalf] <= H_FULL;
            wrPtr             <= '0;
            wrHalf            <= ~wrHalf;
          end else begin
            wrPtr <= wrPtr + 1'b1;
          end
        end else begin
          overflowErr <= 1'b1;
        end
      end
      // Core reads.
      if (rdFire) begin
        if (rdLast) begin
          halfState[rdHalf] <= H_EMPTY;
          rdPtr             <= '0;
          rdHalf            <= ~rdHalf;
        end else begin
          rdPtr <= rdPtr + 1'b1;
        end
      end
    end
  end

  // R7: an unaccepted write raises the flag on the next cycle.
  a_r7_drop_flags: assert property (@(posedge clk) disable iff (!rstN)
    wrValid && !start && (halfState[wrHalf] != H_WAIT) |=> overflowErr);

  // R7: the flag is sticky until start.
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rstN)
    overflowErr && !start |=> overflowErr);

  // R9: a read with nothing available moves no read state.
  a_r9_idle_read: assert property (@(posedge clk) disable iff (!rstN)
    rdEn && !rdValid && !start |=> $stable(rdPtr) && $stable(rdHalf));

  // R6: every request pulse is paid for out of the block total.
  a_r6_req_consumes: assert property (@(posedge clk) disable iff (!rstN)
    refillReq |-> remaining < $past(remaining));

  // R8: start clears the flag and suppresses a request in the next cycle.
  a_r8_start_clears: assert property (@(posedge clk) disable iff (!rstN)
    start |=> !overflowErr && !refillReq && !rdValid);

  // R3: every live half expects a non-zero length no larger than the burst.
  for (genvar h = 0; h < 2; h++) begin : g_lenChk
    a_r3_len_in_range: assert property (@(posedge clk) disable iff (!rstN)
      (halfState[h] != H_EMPTY) |-> (halfLen[h] != '0) && (halfLen[h] <= burstW));
  end

endmodule

// File: rtl/metric_pingpong_dpath.sv
module metric_pingpong_dpath
  import metric_pingpong_pkg::*;
#(
  parameter int DATA_W     = 64,
  parameter int HALF_WORDS = 16,
  localparam int PTR_W     = $clog2(HALF_WORDS),
  localparam int DEPTH     = 2 * HALF_WORDS
) (
  input  logic              clk,
  input  logic              rstN,
  input  ppStrobe_t         strobe,
  input  logic [PTR_W:0]    wrAddr,
  input  logic [PTR_W:0]    rdAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);

  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (strobe.memWe) store[wrAddr] <= wrData;
  end

  assign rdData = store[rdAddr];

  // R4: a write never lands in the half the core is reading.
  a_r4_no_clobber: assert property (@(posedge clk) disable iff (!rstN)
    strobe.memWe && strobe.rdLive |-> wrAddr[PTR_W] != rdAddr[PTR_W]);

endmodule

// File: rtl/metric_pingpong.sv
module metric_pingpong
  import metric_pingpong_pkg::*;
#(
  parameter int DATA_W     = 64,
  parameter int HALF_WORDS = 16,
  parameter int LEN_W      = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [1:0]        rateSel,
  input  logic [3:0]        burstCode,
  input  logic [LEN_W-1:0]  blockWords,
  input  logic              wrValid,
  input  logic [DATA_W-1:0] wrData,
  output logic              refillReq,
  input  logic              rdEn,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic              overflowErr
);

  localparam int PTR_W = $clog2(HALF_WORDS);

  ppStrobe_t      strobe;
  logic [PTR_W:0] wrAddr, rdAddr;

  metric_pingpong_ctrl #(
    .HALF_WORDS(HALF_WORDS),
    .LEN_W     (LEN_W)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .rateSel    (rateSel),
    .burstCode  (burstCode),
    .blockWords (blockWords),
    .wrValid    (wrValid),
    .rdEn       (rdEn),
    .refillReq  (refillReq),
    .rdValid    (rdValid),
    .overflowErr(overflowErr),
    .wrAddr     (wrAddr),
    .rdAddr     (rdAddr),
    .strobe     (strobe)
  );

  metric_pingpong_dpath #(
    .DATA_W    (DATA_W),
    .HALF_WORDS(HALF_WORDS)
  ) u_dpath (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .wrAddr(wrAddr),
    .rdAddr(rdAddr),
    .wrData(wrData),
    .rdData(rdData)
  );

endmodule

// File: tb/metric_pingpong_bench.sv
module metric_pingpong_bench;
  localparam int DW = 64;
  localparam int HW = 16;
  localparam int LW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [1:0]    rateSel = '0;
  logic [3:0]    burstCode = '0;
  logic [LW-1:0] blockWords = '0;
  logic          wrValid = 1'b0;
  logic [DW-1:0] wrData = '0;
  logic          rdEn = 1'b0;
  logic          refillReq, rdValid, overflowErr;
  logic [DW-1:0] rdData;

  metric_pingpong #(.DATA_W(DW), .HALF_WORDS(HW), .LEN_W(LW)) u_metric_pingpong (
    .clk(clk), .rstN(rstN), .start(start), .rateSel(rateSel), .burstCode(burstCode),
    .blockWords(blockWords), .wrValid(wrValid), .wrData(wrData), .refillReq(refillReq),
    .rdEn(rdEn), .rdValid(rdValid), .rdData(rdData), .overflowErr(overflowErr)
  );

  always #2 clk = ~clk;  // 250 MHz

  // Owned by the main sequence.
  int checks = 0, errors = 0;
  int blkId = 0, lenM = 0, burstM = 16, forceReq = 0;
  bit rdOn = 0, wrOn = 0, rdForce = 0;
  // Owned by the driver/monitor process.
  int monChecks = 0, monErrors = 0;
  int blkSeen = 0, pendW = 0, leftToReq = 0, reqCount = 0, rcvCount = 0;
  int wordIdx = 0, forceDone = 0;
  int reqCyc [4];
  logic [DW-1:0] expQ [$];
  logic [15:0] lfsr = 16'hACE1;
  // Owned by the clock counter.
  int cyc = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      $display("FAIL watchdog R4 act %0d cycles exp completion", cyc);
      $display("CHECKS %0d ERRORS %0d", checks + monChecks + 1, errors + monErrors + 1);
      $finish;
    end
  end

  // Driver and scoreboard monitor, all on the falling edge.
  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (blkSeen != blkId) begin
      blkSeen = blkId; pendW = 0; leftToReq = lenM; reqCount = 0;
      rcvCount = 0; wordIdx = 0; expQ.delete();
    end
    if (rstN && refillReq) begin
      int n;
      n = (leftToReq < burstM) ? leftToReq : burstM;
      if (reqCount < 4) reqCyc[reqCount] = cyc;
      reqCount++;
      pendW += n;
      leftToReq -= n;
    end
    // Reader: word on rdData now is consumed at the coming edge.
    rdEn = rdForce ? 1'b1 : (rdOn && (lfsr[0] | lfsr[3]));
    if (rdEn && rdValid) begin
      monChecks++;
      if (expQ.size() == 0) begin
        monErrors++;
        $display("FAIL R4 R9 read with empty scoreboard act %h exp none", rdData);
      end else begin
        logic [DW-1:0] e;
        e = expQ.pop_front();
        if (rdData !== e) begin
          monErrors++;
          $display("FAIL R4 R9 data act %h exp %h", rdData, e);
        end
        rcvCount++;
      end
    end
    // Writer.
    if (forceReq != forceDone) begin
      forceDone = forceReq;
      wrValid = 1'b1;
      wrData = 64'hDEAD_BEEF_0BAD_F00D;
    end else if (wrOn && pendW > 0 && (lfsr[5] | lfsr[7])) begin
      wrValid = 1'b1;
      wrData = {16'hB10C, 16'(blkId), 32'(wordIdx)};
      expQ.push_back(wrData);
      wordIdx++;
      pendW--;
    end else begin
      wrValid = 1'b0;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act %0d exp %0d", tag, act, exp);
    end
  endtask

  task automatic beginBlock(input logic [1:0] r, input logic [3:0] c, input int len, input int bst,
                            output int sc);
    @(negedge clk);
    rateSel = r; burstCode = c; blockWords = LW'(len);
    burstM = bst; lenM = len; blkId++;
    rdOn = 0; wrOn = 0; rdForce = 0;
    start = 1'b1; sc = cyc;
    @(negedge clk);
    start = 1'b0;
    check(overflowErr == 1'b0, "R8 overflowErr after start", 64'(overflowErr), 0);
    check(rdValid == 1'b0, "R8 rdValid after start", 64'(rdValid), 0);
    check(refillReq == 1'b0, "R8 refillReq after start", 64'(refillReq), 0);
  endtask

  task automatic runBlock(input logic [1:0] r, input logic [3:0] c, input int len, input int bst,
                          input int holdRd, input int holdWr, input bit timing);
    int sc, expReq, waited;
    expReq = (len + bst - 1) / bst;
    beginBlock(r, c, len, bst, sc);
    rdOn = (holdRd == 0);
    wrOn = (holdWr == 0);
    if (holdWr > 0) begin
      rdForce = 1;
      repeat (holdWr) @(negedge clk);
      check(rcvCount == 0, "R9 no word consumed before any write", 64'(rcvCount), 0);
      rdForce = 0; rdOn = (holdRd == 0); wrOn = 1;
    end
    if (holdRd > 0) begin
      repeat (holdRd) @(negedge clk);
      check(reqCount == ((expReq < 2) ? expReq : 2), "R5 no request while both halves busy",
            64'(reqCount), 64'((expReq < 2) ? expReq : 2));
      rdOn = 1;
    end
    waited = 0;
    while (rcvCount < len && waited < 4000) begin
      @(negedge clk);
      waited++;
    end
    repeat (20) @(negedge clk);
    check(rcvCount == len, "R4 words delivered", 64'(rcvCount), 64'(len));
    check(reqCount == expReq, "R3 R6 request count", 64'(reqCount), 64'(expReq));
    check(overflowErr == 1'b0, "R7 no overflow in normal run", 64'(overflowErr), 0);
    check(rdValid == 1'b0, "R6 buffer drained", 64'(rdValid), 0);
    if (timing) begin
      check(reqCyc[0] == sc + 2, "R2 first request timing", 64'(reqCyc[0]), 64'(sc + 2));
      check(reqCyc[1] == sc + 3, "R2 second request timing", 64'(reqCyc[1]), 64'(sc + 3));
    end
    rdOn = 0; wrOn = 0;
  endtask

  initial begin
    int sc;
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check(refillReq == 1'b0, "R1 refillReq in reset", 64'(refillReq), 0);
    check(rdValid == 1'b0, "R1 rdValid in reset", 64'(rdValid), 0);
    check(overflowErr == 1'b0, "R1 overflowErr in reset", 64'(overflowErr), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(refillReq == 1'b0 && rdValid == 1'b0, "R1 idle after reset", 64'({refillReq, rdValid}), 0);

    runBlock(2'b00, 4'd3, 40, 16, 0, 0, 1);   // R3 rate 1/4 long
    runBlock(2'b00, 4'd1, 40, 8, 0, 0, 1);    // R3 rate 1/4 short
    runBlock(2'b01, 4'd7, 35, 16, 0, 0, 0);   // R3 rate 1/3 long
    runBlock(2'b01, 4'd3, 20, 8, 0, 8, 0);    // R9 reads before writes
    runBlock(2'b10, 4'd15, 16, 16, 0, 0, 0);  // R6 single exact request
    runBlock(2'b10, 4'd7, 64, 8, 40, 0, 0);   // R5 stalled reader
    runBlock(2'b11, 4'd15, 33, 16, 0, 0, 0);  // R3 rate select 11
    runBlock(2'b10, 4'd5, 24, 8, 0, 0, 0);    // R3 unlisted code gives short
    runBlock(2'b10, 4'd15, 0, 16, 0, 0, 0);   // R6 zero-length block

    // R7: stray write with nothing outstanding.
    @(negedge clk);
    forceReq++;
    repeat (3) @(negedge clk);
    check(overflowErr == 1'b1, "R7 stray write flags", 64'(overflowErr), 1);
    check(rdValid == 1'b0, "R7 stray write dropped", 64'(rdValid), 0);
    repeat (5) @(negedge clk);
    check(overflowErr == 1'b1, "R7 flag sticky", 64'(overflowErr), 1);

    // R8: fill both halves, then abandon with a new start.
    beginBlock(2'b00, 4'd3, 48, 16, sc);
    wrOn = 1;
    repeat (60) @(negedge clk);
    check(rdValid == 1'b1, "R4 halves filled while reader idle", 64'(rdValid), 1);
    check(reqCount == 2, "R5 two priming requests only", 64'(reqCount), 2);
    wrOn = 0;
    runBlock(2'b01, 4'd7, 24, 16, 0, 0, 1);

    $display("CHECKS %0d ERRORS %0d", checks + monChecks, errors + monErrors);
    $finish;
  end

endmodule